// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timer

The block holds two independent down-counting timers: a general-purpose timer (channel 0) and a real-time-clock timer (channel 1). Each timer pairs a prescaler with a main counter. While a timer is enabled and running, its prescaler counts down by one per clock. When the prescaler sits at zero on an active cycle, it reloads from its preset and issues a tick. Each tick lowers the counter by one. A tick that finds the counter already at zero is an expiry. An expiry raises a one-cycle interrupt pulse. The counter then either reloads from its preset and carries on, or parks at zero and stops.

Software reaches the block through a simple 32-bit register bus. The bus has a write strobe, an address and write data, plus a combinational read-data return. Each timer has a counter preset and a scaler preset. The live counter and scaler values come back on reads. Both timers are steered by one shared control word that cannot be read back. That word holds a 4-bit command field per timer. Two bits of each field are stored mode state. The other two bits are load strobes that act only in the cycle of the write.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset all live counters, scalers and presets are zero, both timers are disabled and stopped, and both interrupt outputs are low.
- R2: The control word at offset 0x98 carries the general-purpose field in bits 3:0 and the real-time-clock field in bits 11:8. Within a field, bit 0 = reload-at-zero mode, bit 1 = counter load strobe, bit 2 = count enable, bit 3 = scaler load strobe. Every control write overwrites the mode and enable bits of both fields.
- R3: A counter load strobe copies the counter preset into the live counter and marks the timer running. A scaler load strobe copies the scaler preset into the live scaler. Loads take effect whether or not counting is enabled.
- R4: While the enable bit is 0, the scaler and counter of that timer hold their values. Setting it back to 1 resumes counting from the held values.
- R5: With scaler preset S and counter preset C loaded and enabled by a write at clock edge W, the interrupt is high for exactly the one cycle following edge W+(S+1)(C+1).
- R6: In reload mode the counter reloads its preset on expiry, and the interrupt repeats every (S+1)(C+1) cycles.
- R7: In stop mode the counter stays at zero after expiry. The timer raises no further interrupt until a new counter load.
- R8: A counter load strobe on the same edge at which the counter would expire wins. No interrupt is raised and the count restarts from the preset.
- R9: Offsets 0x80/0x84 are the real-time-clock counter/scaler and 0x88/0x8C are the general-purpose counter/scaler. Writes there set only the preset. Reads there return the live value. Reads of the control offset or of unmapped offsets return zero.
- R10: The two timers run independently and may raise their interrupts in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_gp | output | 1 | General-purpose timer interrupt pulse |
| irq_rtc | output | 1 | Real-time-clock timer interrupt pulse |

## Verification
Two functions can land on the same clock edge: a counter load command, and the expiry that the running count would produce on that edge. The bench sets a short reload-mode count and issues a second load exactly on the edge where expiry falls due. It then expects no pulse there, and one full period later a single pulse. A second coincidence is both timers expiring together from one shared control write. The scoreboard must then accept two pulses in the same cycle, one per channel.

// File: rtl/timer_unit_pkg.sv
package timer_unit_pkg;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 8;
  localparam int N_CH         = 2;
  localparam int FIELD_STRIDE = 8;
  localparam int FIELD_W      = 4;

  localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h98;

  // Field layout: bit3 scaler load, bit2 enable, bit1 counter load, bit0 reload
  typedef struct packed {
    logic scl_load;
    logic enable;
    logic cnt_load;
    logic reload;
  } tmr_field_t;

  // Channel 0 = general-purpose timer, channel 1 = real-time-clock timer
  function automatic logic [ADDR_W-1:0] cnt_offset(input int ch);
    return (ch == 0) ? 8'h88 : 8'h80;
  endfunction

  function automatic logic [ADDR_W-1:0] scl_offset(input int ch);
    return (ch == 0) ? 8'h8C : 8'h84;
  endfunction
endpackage

// File: rtl/timer_bus_decode.sv
module timer_bus_decode
  import timer_unit_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SCL_W = 16
) (
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [N_CH-1:0][CNT_W-1:0]    live_cnt,
  input  logic [N_CH-1:0][SCL_W-1:0]    live_scl,
  output logic                          ctrl_we,
  output logic [N_CH-1:0]               cnt_pre_we,
  output logic [N_CH-1:0]               scl_pre_we,
  output logic [DATA_W-1:0]             rdata
);
  assign ctrl_we = bus_we && (bus_addr == CTRL_OFS);

  for (genvar i = 0; i < N_CH; i++) begin : g_we
    assign cnt_pre_we[i] = bus_we && (bus_addr == cnt_offset(i));
    assign scl_pre_we[i] = bus_we && (bus_addr == scl_offset(i));
  end

  // Control word is write-only; reads of it and of holes return zero
  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (bus_addr == cnt_offset(i)) rdata = DATA_W'(live_cnt[i]);
      if (bus_addr == scl_offset(i)) rdata = DATA_W'(live_scl[i]);
    end
  end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_unit_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SCL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  tmr_field_t       cmd,
  input  logic             cnt_pre_we,
  input  logic             scl_pre_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [SCL_W-1:0] scl_q,
  output logic [CNT_W-1:0] cnt_pre_q,
  output logic             active,
  output logic             reload_q,
  output logic             cnt_load,
  output logic             expire,
  output logic             irq_q
);
  logic [SCL_W-1:0] scl_pre_q;
  logic             en_q;
  logic             run_q;
  logic             scl_load;
  logic             tick;

  function automatic logic [SCL_W-1:0] scaler_step(input logic [SCL_W-1:0] cur,
                                                   input logic [SCL_W-1:0] pre);
    return (cur == '0) ? pre : cur - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] counter_step(input logic [CNT_W-1:0] cur,
                                                    input logic [CNT_W-1:0] pre,
                                                    input logic             rld);
    if (cur != '0) return cur - 1'b1;
    return rld ? pre : cur;
  endfunction

  assign cnt_load = cmd_we && cmd.cnt_load;
  assign scl_load = cmd_we && cmd.scl_load;
  assign active   = en_q && run_q;
  assign tick     = active && (scl_q == '0) && !scl_load;
  assign expire   = tick && (cnt_q == '0) && !cnt_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      scl_q     <= '0;
      cnt_pre_q <= '0;
      scl_pre_q <= '0;
      en_q      <= 1'b0;
      reload_q  <= 1'b0;
      run_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (cnt_pre_we) cnt_pre_q <= wdata;
      if (scl_pre_we) scl_pre_q <= wdata[SCL_W-1:0];
      if (cmd_we) begin
        en_q     <= cmd.enable;
        reload_q <= cmd.reload;
      end
      if (scl_load)    scl_q <= scl_pre_q;
      else if (active) scl_q <= scaler_step(scl_q, scl_pre_q);
      if (cnt_load) begin
        cnt_q <= cnt_pre_q;
        run_q <= 1'b1;
      end else if (tick) begin
        cnt_q <= counter_step(cnt_q, cnt_pre_q, reload_q);
        if (expire && !reload_q) run_q <= 1'b0;
      end
      irq_q <= expire;
    end
  end
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import timer_unit_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SCL_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_gp,
  output logic        irq_rtc
);
  logic                       ctrl_we;
  logic [N_CH-1:0]            cnt_pre_we;
  logic [N_CH-1:0]            scl_pre_we;
  logic [N_CH-1:0][CNT_W-1:0] live_cnt;
  logic [N_CH-1:0][SCL_W-1:0] live_scl;
  logic [N_CH-1:0][CNT_W-1:0] cnt_preset;
  logic [N_CH-1:0]            ch_active;
  logic [N_CH-1:0]            ch_reload;
  logic [N_CH-1:0]            ch_cnt_load;
  logic [N_CH-1:0]            ch_expire;
  logic [N_CH-1:0]            irq_vec;

  timer_bus_decode #(.CNT_W(CNT_W), .SCL_W(SCL_W)) u_dec (
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .live_cnt   (live_cnt),
    .live_scl   (live_scl),
    .ctrl_we    (ctrl_we),
    .cnt_pre_we (cnt_pre_we),
    .scl_pre_we (scl_pre_we),
    .rdata      (bus_rdata)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    tmr_field_t field;
    assign field = tmr_field_t'(bus_wdata[i*FIELD_STRIDE +: FIELD_W]);

    timer_channel #(.CNT_W(CNT_W), .SCL_W(SCL_W)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_we     (ctrl_we),
      .cmd        (field),
      .cnt_pre_we (cnt_pre_we[i]),
      .scl_pre_we (scl_pre_we[i]),
      .wdata      (bus_wdata[CNT_W-1:0]),
      .cnt_q      (live_cnt[i]),
      .scl_q      (live_scl[i]),
      .cnt_pre_q  (cnt_preset[i]),
      .active     (ch_active[i]),
      .reload_q   (ch_reload[i]),
      .cnt_load   (ch_cnt_load[i]),
      .expire     (ch_expire[i]),
      .irq_q      (irq_vec[i])
    );
  end

  assign irq_gp  = irq_vec[0];
  assign irq_rtc = irq_vec[1];
endmodule

// File: rtl/dual_timer_unit_chk.sv
module dual_timer_unit_chk #(
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            irq,
  input logic [1:0][CNT_W-1:0] cnt,
  input logic [1:0][CNT_W-1:0] cnt_pre,
  input logic [1:0]            expire,
  input logic [1:0]            reload,
  input logic [1:0]            active,
  input logic [1:0]            cnt_load
);
  for (genvar i = 0; i < 2; i++) begin : g_prop
    assert_load_copies_preset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load[i] |=> cnt[i] == $past(cnt_pre[i]));

    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!active[i] && !cnt_load[i]) |=> $stable(cnt[i]));

    assert_irq_after_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> $past(cnt[i]) == '0);

    assert_reload_restores_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[i] && reload[i]) |=> cnt[i] == $past(cnt_pre[i]));

    assert_stop_parks_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[i] && !reload[i]) |=> cnt[i] == '0);

    assert_load_beats_expiry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load[i] |=> !irq[i]);
  end
endmodule

bind dual_timer_unit dual_timer_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq_vec),
  .cnt      (live_cnt),
  .cnt_pre  (cnt_preset),
  .expire   (ch_expire),
  .reload   (ch_reload),
  .active   (ch_active),
  .cnt_load (ch_cnt_load)
);

// File: tb/tb_dual_timer_unit.sv
`timescale 1ns/1ps
module tb_dual_timer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_gp;
  logic        irq_rtc;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int    ch;
    int    at;
    string req;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_timer_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_gp(irq_gp), .irq_rtc(irq_rtc)
  );

  function automatic void check(input bit ok, input string req, input string what,
                                input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endfunction

  function automatic void judge(input int ch);
    exp_t e;
    if (q.size() == 0) begin
      check(1'b0, "R7", $sformatf("unexpected pulse ch%0d at cycle", ch), cyc, -1);
    end else begin
      e = q.pop_front();
      check(e.ch == ch, e.req, "pulse channel", ch, e.ch);
      check(e.at == cyc, e.req, $sformatf("pulse cycle ch%0d", ch), cyc, e.at);
    end
  endfunction

  // Monitor: scoreboard side
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_gp)  judge(0);
      if (irq_rtc) judge(1);
    end
  end

  function automatic void expect_irq(input int ch, input int at, input string req);
    exp_t e;
    e.ch = ch; e.at = at; e.req = req;
    q.push_back(e);
  endfunction

  // Driver: called at a falling edge, returns at the falling edge after the write edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int edge_no);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    edge_no   = cyc + 1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic wr_n(input logic [7:0] a, input logic [31:0] d);
    int unused_edge;
    wr(a, d, unused_edge);
  endtask

  task automatic rd(input logic [7:0] a, input longint exp, input string req);
    bus_addr = a;
    #1;
    check(bus_rdata == exp, req, $sformatf("read 0x%0h", a), bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1600000;
    check(1'b0, "R1", "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w;
    int w3;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    rd(8'h80, 0, "R1");
    rd(8'h84, 0, "R1");
    rd(8'h88, 0, "R1");
    rd(8'h8C, 0, "R1");
    check(!irq_gp && !irq_rtc, "R1", "irq low after reset", {irq_gp, irq_rtc}, 0);
    idle(1);

    // R5/R7: general timer, stop mode, S=2 C=3 -> pulse 12 edges after the write
    wr_n(8'h88, 3);
    wr_n(8'h8C, 2);
    wr(8'h98, 32'h0000_000E, w);
    expect_irq(0, w + 12, "R5");
    idle(20);
    rd(8'h88, 0, "R7");

    // R6: real-time-clock timer, reload mode, S=3 C=1 -> period 8
    wr_n(8'h80, 1);
    wr_n(8'h84, 3);
    wr(8'h98, 32'h0000_0F00, w);
    expect_irq(1, w + 8,  "R6");
    expect_irq(1, w + 16, "R6");
    expect_irq(1, w + 24, "R6");
    idle(26);
    wr_n(8'h98, 32'h0);
    idle(10);

    // R4: hold while disabled, then resume from the held value
    wr_n(8'h88, 5);
    wr_n(8'h8C, 0);
    wr(8'h98, 32'h0000_000E, w);
    wr_n(8'h98, 32'h0);          // one decrement happens on this edge -> 4
    idle(5);
    rd(8'h88, 4, "R4");
    wr(8'h98, 32'h0000_0004, w3);
    expect_irq(0, w3 + 5, "R4");
    idle(12);

    // R2/R3/R9: load without enable in the upper field, presets vs live values
    wr_n(8'h80, 7);
    wr_n(8'h84, 9);
    wr_n(8'h98, 32'h0000_0A00);
    idle(6);
    rd(8'h80, 7, "R3");
    rd(8'h84, 9, "R2");
    wr_n(8'h80, 100);
    rd(8'h80, 7, "R9");

    // R8: reload on the very edge of expiry wins
    wr_n(8'h88, 2);
    wr_n(8'h8C, 0);
    wr(8'h98, 32'h0000_000F, w);
    idle(2);
    wr(8'h98, 32'h0000_000F, w3);
    check(w3 == w + 3, "R8", "collision edge alignment", w3, w + 3);
    expect_irq(0, w3 + 3, "R8");
    idle(3);
    wr_n(8'h98, 32'h0);
    idle(8);

    // R10: both timers from one write, same cycle
    wr_n(8'h88, 1);
    wr_n(8'h8C, 1);
    wr_n(8'h80, 1);
    wr_n(8'h84, 1);
    wr(8'h98, 32'h0000_0E0E, w);
    expect_irq(0, w + 4, "R10");
    expect_irq(1, w + 4, "R10");
    idle(12);
    rd(8'h88, 0, "R10");
    rd(8'h80, 0, "R10");

    // R9: write-only control and holes read as zero
    rd(8'h98, 0, "R9");
    rd(8'h40, 0, "R9");

    idle(5);
    check(q.size() == 0, "R5", "missing pulses", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule